// File: doc/BRIEF.md
# Segment lookaside buffer array

This block is a small, fully associative table of segment translation entries that sits in front of a hashed page-table walker. Every entry holds a 36-bit effective segment tag, a valid flag and a 64-bit virtual segment word. The top two bits of that word give the segment size. An effective address is presented on the lookup port. One cycle later the block reports whether a live entry covers it, which slot matched and that slot's virtual segment word.

Software-visible maintenance uses three paths. A command port stores an entry by slot number or reads back either half of an entry, and it refuses illegal requests with an error flag. An address-directed invalidate drops the entry that covers a given address. A bulk invalidate drops every entry except slot 0. Whenever a maintenance operation actually removes a live mapping, the block raises a single-cycle pulse telling the downstream translation cache to flush.

Top module: `segtab`

## Requirements
- R1: After reset every entry reads back as all zeros, no lookup hits, and `lk_done`, `cmd_done`, `cmd_err` and `tlb_flush` are low.
- R2: An entry whose size field (virtual word bits 63:62) is `00` (256 MB) hits when it is valid and its tag equals address bits 63:28.
- R3: An entry whose size field is `01` (1 TB) hits when it is valid and its tag equals address bits 63:40 followed by twelve zero bits. Address bits 39:28 play no part, and a 1 TB entry stored with nonzero tag bits 11:0 never hits.
- R4: The lookup result appears in the cycle after `lk_valid`, with `lk_done` high. When several entries hit, the lowest slot wins. A miss returns `lk_hit`=0, `lk_slot`=0 and `lk_vsw`=0.
- R5: `inv_all` clears the valid flag of every slot except slot 0. `tlb_flush` pulses in the next cycle only if some slot from 1 upward was valid.
- R6: `inv_addr_valid` clears the valid flag of the lowest-numbered entry that `inv_addr` hits, and `tlb_flush` pulses in the next cycle. With no hit, nothing changes and no pulse is given.
- R7: A store (`cmd_op`=0) is rejected with `cmd_err` when any bit of index bits 11:0 at or above log2(N_ENTRIES) is set. Index bits above 11 are not examined.
- R8: A store is rejected when the size field of `cmd_data` is `10` or `11`.
- R9: With `HAS_1T`=0, a store whose size field is `01` is rejected.
- R10: An accepted store writes index bits 63:28 as the tag, index bit 27 as the valid flag and `cmd_data` unchanged into slot index[log2(N)-1:0]. A rejected store changes nothing. `cmd_done` and `cmd_err` answer one cycle after `cmd_valid`.
- R11: `cmd_op`=1 returns {tag, valid, 27 zeros} and `cmd_op`=2 returns the virtual word, one cycle later. Index bits 11:0 at or above N_ENTRIES, or `cmd_op`=3, give `cmd_err`=1 with `cmd_rdata`=0.
- R12: When a store and an invalidate land in the same cycle, both invalidates act on the old table contents and the store's write to its slot takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Effective address to translate |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A live entry covers the address |
| lk_slot | output | log2(N_ENTRIES) | Winning slot |
| lk_vsw | output | 64 | Virtual segment word of the winning slot |
| inv_addr_valid | input | 1 | Invalidate the entry covering inv_addr |
| inv_addr | input | 64 | Address for the directed invalidate |
| inv_all | input | 1 | Invalidate all slots but slot 0 |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 store, 1 read tag half, 2 read virtual word, 3 reserved |
| cmd_index | input | 64 | Tag, valid flag and slot number |
| cmd_data | input | 64 | Virtual segment word to store |
| cmd_done | output | 1 | Command answered |
| cmd_err | output | 1 | Command was illegal |
| cmd_rdata | output | 64 | Read data |
| tlb_flush | output | 1 | One-cycle flush request |

## Verification
The bench builds two copies with eight entries: one with 1 TB segments enabled and one with them disabled, driven in parallel. Eight slots put the first illegal slot bit at bit 3, inside the 12-bit index field. This makes out-of-range stores and reads reachable, along with index bits above the field that must be ignored. With eight slots the bench can also fill the table with overlapping tags to exercise slot priority. The second copy exposes the 1 TB rejection, which the first cannot show.

// File: rtl/segtab_pkg.sv
package segtab_pkg;
   localparam int WORD_W      = 64;
   localparam int SEG_LSB     = 28;
   localparam int TB_LSB      = 40;
   localparam int VLD_BIT     = 27;
   localparam int TAG_W       = WORD_W - SEG_LSB;
   localparam int TB_ZERO_W   = TB_LSB - SEG_LSB;
   localparam int IDX_FIELD_W = 12;

   localparam logic [1:0] SZ_256M = 2'b00;
   localparam logic [1:0] SZ_1T   = 2'b01;

   typedef enum logic [1:0] {
      OP_STORE  = 2'd0,
      OP_RD_SEG = 2'd1,
      OP_RD_VSW = 2'd2,
      OP_RSVD   = 2'd3
   } cmd_op_e;

   typedef struct packed {
      logic [TAG_W-1:0]  tag;
      logic              vld;
      logic [WORD_W-1:0] vsw;
   } seg_entry_t;
endpackage

// File: rtl/segtab_match.sv
module segtab_match
   import segtab_pkg::*;
#(
   parameter  int N_ENTRIES = 32,
   localparam int SLOT_W    = $clog2(N_ENTRIES)
) (
   input  logic [TAG_W-1:0]                seg,
   input  logic [N_ENTRIES-1:0][TAG_W-1:0] tags,
   input  logic [N_ENTRIES-1:0]            vlds,
   input  logic [N_ENTRIES-1:0][1:0]       sizes,
   output logic                            hit,
   output logic [SLOT_W-1:0]               slot
);
   logic [TAG_W-1:0]     seg_tb;
   logic [N_ENTRIES-1:0] m;

   assign seg_tb = {seg[TAG_W-1:TB_ZERO_W], {TB_ZERO_W{1'b0}}};

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
      assign m[g] = vlds[g] &&
                    (((sizes[g] == SZ_256M) && (tags[g] == seg)) ||
                     ((sizes[g] == SZ_1T)   && (tags[g] == seg_tb)));
   end

   always_comb begin
      hit  = 1'b0;
      slot = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (m[i]) begin
            hit  = 1'b1;
            slot = SLOT_W'(i);
         end
      end
   end
endmodule

// File: rtl/segtab_wr_check.sv
module segtab_wr_check
   import segtab_pkg::*;
#(
   parameter int N_ENTRIES = 32,
   parameter bit HAS_1T    = 1'b1
) (
   input  logic [IDX_FIELD_W-1:0] slot_field,
   input  logic [1:0]             size,
   output logic                   reject
);
   localparam logic [IDX_FIELD_W-1:0] OVER_MASK = ~IDX_FIELD_W'(N_ENTRIES - 1);

   logic slot_bad, size_bad, tb_bad;

   assign slot_bad = |(slot_field & OVER_MASK);
   assign size_bad = (size != SZ_256M) && (size != SZ_1T);

   if (HAS_1T) begin : g_tb_on
      assign tb_bad = 1'b0;
   end else begin : g_tb_off
      assign tb_bad = (size == SZ_1T);
   end

   assign reject = slot_bad | size_bad | tb_bad;
endmodule

// File: rtl/segtab.sv
module segtab
   import segtab_pkg::*;
#(
   parameter  int N_ENTRIES = 32,
   parameter  bit HAS_1T    = 1'b1,
   localparam int SLOT_W    = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [WORD_W-1:0] lk_addr,
   output logic              lk_done,
   output logic              lk_hit,
   output logic [SLOT_W-1:0] lk_slot,
   output logic [WORD_W-1:0] lk_vsw,
   input  logic              inv_addr_valid,
   input  logic [WORD_W-1:0] inv_addr,
   input  logic              inv_all,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [WORD_W-1:0] cmd_index,
   input  logic [WORD_W-1:0] cmd_data,
   output logic              cmd_done,
   output logic              cmd_err,
   output logic [WORD_W-1:0] cmd_rdata,
   output logic              tlb_flush
);
   if (N_ENTRIES < 2 || N_ENTRIES > (1 << IDX_FIELD_W) ||
       (N_ENTRIES & (N_ENTRIES - 1)) != 0) begin : g_bad_count
      $error("segtab: N_ENTRIES must be a power of two from 2 to 4096");
   end

   seg_entry_t [N_ENTRIES-1:0]            tab_q;
   logic       [N_ENTRIES-1:0][TAG_W-1:0] tags;
   logic       [N_ENTRIES-1:0]            vlds;
   logic       [N_ENTRIES-1:0][1:0]       sizes;
   logic       [N_ENTRIES-1:0]            clr;

   logic              lk_hit_c, inv_hit_c, wr_rej, store_ok, rd_oob, any_upper;
   logic [SLOT_W-1:0] lk_slot_c, inv_slot_c, wslot;
   logic              err_d;
   logic [WORD_W-1:0] rdata_d;
   seg_entry_t        rd_ent;
   cmd_op_e           op;
   logic              unused_bits;

   assign unused_bits = ^{lk_addr[SEG_LSB-1:0], inv_addr[SEG_LSB-1:0],
                          cmd_index[VLD_BIT-1:IDX_FIELD_W]};

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      assign tags[g]  = tab_q[g].tag;
      assign vlds[g]  = tab_q[g].vld;
      assign sizes[g] = tab_q[g].vsw[WORD_W-1 -: 2];
      if (g == 0) begin : g_keep
         assign clr[g] = inv_addr_valid && inv_hit_c && (inv_slot_c == '0);
      end else begin : g_drop
         assign clr[g] = inv_all ||
                         (inv_addr_valid && inv_hit_c && (inv_slot_c == SLOT_W'(g)));
      end
   end

   assign any_upper = |vlds[N_ENTRIES-1:1];

   segtab_match #(.N_ENTRIES(N_ENTRIES)) u_lk_match (
      .seg(lk_addr[WORD_W-1:SEG_LSB]), .tags(tags), .vlds(vlds), .sizes(sizes),
      .hit(lk_hit_c), .slot(lk_slot_c)
   );

   segtab_match #(.N_ENTRIES(N_ENTRIES)) u_inv_match (
      .seg(inv_addr[WORD_W-1:SEG_LSB]), .tags(tags), .vlds(vlds), .sizes(sizes),
      .hit(inv_hit_c), .slot(inv_slot_c)
   );

   segtab_wr_check #(.N_ENTRIES(N_ENTRIES), .HAS_1T(HAS_1T)) u_wr_check (
      .slot_field(cmd_index[IDX_FIELD_W-1:0]),
      .size(cmd_data[WORD_W-1 -: 2]),
      .reject(wr_rej)
   );

   assign op       = cmd_op_e'(cmd_op);
   assign wslot    = cmd_index[SLOT_W-1:0];
   assign store_ok = cmd_valid && (op == OP_STORE) && !wr_rej;
   assign rd_oob   = {1'b0, cmd_index[IDX_FIELD_W-1:0]} >= (IDX_FIELD_W + 1)'(N_ENTRIES);
   assign rd_ent   = tab_q[wslot];

   always_comb begin
      err_d   = 1'b0;
      rdata_d = '0;
      if (cmd_valid) begin
         unique case (op)
            OP_STORE:  err_d = wr_rej;
            OP_RD_SEG: begin
               err_d = rd_oob;
               if (!rd_oob) rdata_d = {rd_ent.tag, rd_ent.vld, {VLD_BIT{1'b0}}};
            end
            OP_RD_VSW: begin
               err_d = rd_oob;
               if (!rd_oob) rdata_d = rd_ent.vsw;
            end
            default:   err_d = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tab_q     <= '0;
         lk_done   <= 1'b0;
         lk_hit    <= 1'b0;
         lk_slot   <= '0;
         lk_vsw    <= '0;
         cmd_done  <= 1'b0;
         cmd_err   <= 1'b0;
         cmd_rdata <= '0;
         tlb_flush <= 1'b0;
      end else begin
         for (int i = 0; i < N_ENTRIES; i++) begin
            if (store_ok && (wslot == SLOT_W'(i)))
               tab_q[i] <= {cmd_index[WORD_W-1:SEG_LSB], cmd_index[VLD_BIT], cmd_data};
            else if (clr[i])
               tab_q[i].vld <= 1'b0;
         end
         lk_done   <= lk_valid;
         lk_hit    <= lk_valid && lk_hit_c;
         lk_slot   <= (lk_valid && lk_hit_c) ? lk_slot_c : '0;
         lk_vsw    <= (lk_valid && lk_hit_c) ? tab_q[lk_slot_c].vsw : '0;
         cmd_done  <= cmd_valid;
         cmd_err   <= err_d;
         cmd_rdata <= rdata_d;
         tlb_flush <= (inv_all && any_upper) || (inv_addr_valid && inv_hit_c);
      end
   end
endmodule

// File: rtl/segtab_chk.sv
module segtab_chk
   import segtab_pkg::*;
#(
   parameter  int N_ENTRIES = 32,
   parameter  bit HAS_1T    = 1'b1,
   localparam int SLOT_W    = $clog2(N_ENTRIES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic              lk_done,
   input logic              lk_hit,
   input logic [SLOT_W-1:0] lk_slot,
   input logic [WORD_W-1:0] lk_vsw,
   input logic              inv_addr_valid,
   input logic              inv_all,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [WORD_W-1:0] cmd_index,
   input logic [WORD_W-1:0] cmd_data,
   input logic              cmd_done,
   input logic              cmd_err,
   input logic [WORD_W-1:0] cmd_rdata,
   input logic              tlb_flush
);
   localparam logic [IDX_FIELD_W-1:0] OVER_MASK = ~IDX_FIELD_W'(N_ENTRIES - 1);

   logic unused_chk;
   logic is_store, is_read, oob;

   assign unused_chk = ^{cmd_index[WORD_W-1:IDX_FIELD_W], cmd_data[WORD_W-3:0]};
   assign is_store   = cmd_valid && (cmd_op == OP_STORE);
   assign is_read    = cmd_valid && ((cmd_op == OP_RD_SEG) || (cmd_op == OP_RD_VSW));
   assign oob        = {1'b0, cmd_index[IDX_FIELD_W-1:0]} >= (IDX_FIELD_W + 1)'(N_ENTRIES);

   // R4
   lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> lk_done);

   // R4
   miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && !lk_hit) |-> (lk_slot == '0 && lk_vsw == '0));

   // R5 R6
   flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_flush |-> $past(inv_all || inv_addr_valid));

   // R10
   cmd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> cmd_done);

   // R7
   slot_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_store && |(cmd_index[IDX_FIELD_W-1:0] & OVER_MASK)) |=> cmd_err);

   // R8
   size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_store && cmd_data[WORD_W-1]) |=> cmd_err);

   // R11
   read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && oob) |=> (cmd_err && cmd_rdata == '0));

   if (!HAS_1T) begin : g_no_tb
      // R9
      tb_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_store && cmd_data[WORD_W-1 -: 2] == SZ_1T) |=> cmd_err);
   end
endmodule

bind segtab segtab_chk #(.N_ENTRIES(N_ENTRIES), .HAS_1T(HAS_1T)) u_segtab_chk (.*);

// File: tb/segtab_bench.sv
module segtab_bench;
   localparam int N  = 8;
   localparam int SW = $clog2(N);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [63:0] lk_addr = '0;
   logic        inv_addr_valid = 1'b0;
   logic [63:0] inv_addr = '0;
   logic        inv_all = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [63:0] cmd_index = '0;
   logic [63:0] cmd_data = '0;

   logic          lk_done, lk_hit, cmd_done, cmd_err, tlb_flush;
   logic [SW-1:0] lk_slot;
   logic [63:0]   lk_vsw, cmd_rdata;
   logic          b_lk_done, b_lk_hit, b_cmd_done, b_cmd_err, b_tlb_flush;
   logic [SW-1:0] b_lk_slot;
   logic [63:0]   b_lk_vsw, b_cmd_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   segtab #(.N_ENTRIES(N), .HAS_1T(1'b1)) u_segtab (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .lk_done(lk_done), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_vsw(lk_vsw),
      .inv_addr_valid(inv_addr_valid), .inv_addr(inv_addr), .inv_all(inv_all),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index),
      .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_err(cmd_err),
      .cmd_rdata(cmd_rdata), .tlb_flush(tlb_flush)
   );

   segtab #(.N_ENTRIES(N), .HAS_1T(1'b0)) u_segtab_no1t (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .lk_done(b_lk_done), .lk_hit(b_lk_hit), .lk_slot(b_lk_slot), .lk_vsw(b_lk_vsw),
      .inv_addr_valid(inv_addr_valid), .inv_addr(inv_addr), .inv_all(inv_all),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index),
      .cmd_data(cmd_data), .cmd_done(b_cmd_done), .cmd_err(b_cmd_err),
      .cmd_rdata(b_cmd_rdata), .tlb_flush(b_tlb_flush)
   );

   function automatic logic [63:0] a256(input logic [35:0] s, input logic [27:0] off);
      return {s, off};
   endfunction

   function automatic logic [63:0] idx256(input logic [35:0] s, input int slot);
      return {s, 1'b1, 15'b0, 12'(slot)};
   endfunction

   function automatic logic [63:0] idx1t(input logic [23:0] s, input logic [11:0] mid,
                                         input int slot);
      return {s, mid, 1'b1, 15'b0, 12'(slot)};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_store(input logic [63:0] idx, input logic [63:0] vw,
                           input string req, input logic exp_err);
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_index = idx; cmd_data = vw;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(req, "store done", 64'(cmd_done), 64'(1'b1));
      chk(req, "store err", 64'(cmd_err), 64'(exp_err));
   endtask

   task automatic do_read(input logic [1:0] op, input logic [63:0] idx, input string req,
                          input logic exp_err, input logic [63:0] exp_data);
      cmd_valid = 1'b1; cmd_op = op; cmd_index = idx; cmd_data = '0;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(req, "read err", 64'(cmd_err), 64'(exp_err));
      chk(req, "read data", cmd_rdata, exp_data);
   endtask

   task automatic do_lookup(input logic [63:0] addr, input string req, input logic exp_hit,
                            input int exp_slot, input logic [63:0] exp_vsw);
      lk_valid = 1'b1; lk_addr = addr;
      @(negedge clk);
      lk_valid = 1'b0;
      chk(req, "lookup done", 64'(lk_done), 64'(1'b1));
      chk(req, "lookup hit", 64'(lk_hit), 64'(exp_hit));
      chk(req, "lookup slot", 64'(lk_slot), 64'(exp_slot));
      chk(req, "lookup vsw", lk_vsw, exp_vsw);
   endtask

   task automatic do_inv_all(input string req, input logic exp_flush);
      inv_all = 1'b1;
      @(negedge clk);
      inv_all = 1'b0;
      chk(req, "flush", 64'(tlb_flush), 64'(exp_flush));
   endtask

   task automatic do_inv_addr(input logic [63:0] addr, input string req, input logic exp_flush);
      inv_addr_valid = 1'b1; inv_addr = addr;
      @(negedge clk);
      inv_addr_valid = 1'b0;
      chk(req, "flush", 64'(tlb_flush), 64'(exp_flush));
   endtask

   task automatic t_reset;
      chk("R1", "lk_done", 64'(lk_done), 64'd0);
      chk("R1", "cmd_done", 64'(cmd_done), 64'd0);
      chk("R1", "tlb_flush", 64'(tlb_flush), 64'd0);
      for (int s = 0; s < N; s++) begin
         do_read(2'd1, 64'(s), "R1", 1'b0, 64'd0);
         do_read(2'd2, 64'(s), "R1", 1'b0, 64'd0);
      end
      do_lookup(64'd0, "R1", 1'b0, 0, 64'd0);
   endtask

   task automatic t_seg256;
      do_store(idx256(36'h123, 2), 64'h0000_0000_0ABC_0000, "R2", 1'b0);
      do_lookup(a256(36'h123, 28'hFFF_FFFF), "R2", 1'b1, 2, 64'h0000_0000_0ABC_0000);
      do_lookup(a256(36'h124, 28'h0), "R2", 1'b0, 0, 64'd0);
   endtask

   task automatic t_seg1t;
      do_store(idx1t(24'h7, 12'h000, 5), 64'h4000_0000_0000_0055, "R3", 1'b0);
      do_lookup({24'h7, 12'hABC, 28'h123_4567}, "R3", 1'b1, 5, 64'h4000_0000_0000_0055);
      do_store(idx1t(24'h9, 12'h001, 6), 64'h4000_0000_0000_0066, "R3", 1'b0);
      do_lookup({24'h9, 12'h001, 28'h0}, "R3", 1'b0, 0, 64'd0);
   endtask

   task automatic t_priority;
      do_store(idx256(36'h123, 4), 64'h44, "R4", 1'b0);
      do_lookup(a256(36'h123, 28'h10), "R4", 1'b1, 2, 64'h0000_0000_0ABC_0000);
      do_store(idx256(36'h123, 1), 64'h11, "R4", 1'b0);
      do_lookup(a256(36'h123, 28'h10), "R4", 1'b1, 1, 64'h11);
   endtask

   task automatic t_store_rules;
      do_store(64'h8, 64'h0, "R7", 1'b1);
      do_store(64'h800, 64'h0, "R7", 1'b1);
      do_store(idx256(36'h77, 3) | 64'h1000, 64'h33, "R7", 1'b0);
      do_read(2'd1, 64'd3, "R10", 1'b0, {36'h77, 1'b1, 27'b0});
      do_read(2'd2, 64'd3, "R10", 1'b0, 64'h33);
      do_store(idx256(36'h99, 3), 64'h8000_0000_0000_0000, "R8", 1'b1);
      do_store(idx256(36'h99, 3), 64'hC000_0000_0000_0000, "R8", 1'b1);
      do_read(2'd1, 64'd3, "R10", 1'b0, {36'h77, 1'b1, 27'b0});
      cmd_valid = 1'b1; cmd_op = 2'd0;
      cmd_index = idx1t(24'hA, 12'h000, 7); cmd_data = 64'h4000_0000_0000_0077;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9", "1T store with support", 64'(cmd_err), 64'd0);
      chk("R9", "1T store without support", 64'(b_cmd_err), 64'd1);
   endtask

   task automatic t_clear_all;
      do_store(idx256(36'h55, 0), 64'h5, "R5", 1'b0);
      do_inv_all("R5", 1'b1);
      do_lookup(a256(36'h55, 28'h0), "R5", 1'b1, 0, 64'h5);
      do_lookup(a256(36'h123, 28'h0), "R5", 1'b0, 0, 64'd0);
      do_read(2'd1, 64'd2, "R5", 1'b0, {36'h123, 1'b0, 27'b0});
      do_inv_all("R5", 1'b0);
      do_read(2'd1, 64'd0, "R5", 1'b0, {36'h55, 1'b1, 27'b0});
   endtask

   task automatic t_clear_addr;
      do_inv_addr(a256(36'h56, 28'h0), "R6", 1'b0);
      do_lookup(a256(36'h55, 28'h0), "R6", 1'b1, 0, 64'h5);
      do_inv_addr(a256(36'h55, 28'hABC), "R6", 1'b1);
      do_lookup(a256(36'h55, 28'h0), "R6", 1'b0, 0, 64'd0);
      do_store(idx256(36'h123, 1), 64'h11, "R6", 1'b0);
      do_store(idx256(36'h123, 2), 64'h22, "R6", 1'b0);
      do_inv_addr(a256(36'h123, 28'h0), "R6", 1'b1);
      do_lookup(a256(36'h123, 28'h0), "R6", 1'b1, 2, 64'h22);
   endtask

   task automatic t_read_rules;
      do_read(2'd1, 64'd8, "R11", 1'b1, 64'd0);
      do_read(2'd2, 64'hFFF, "R11", 1'b1, 64'd0);
      do_read(2'd3, 64'd2, "R11", 1'b1, 64'd0);
      do_read(2'd2, 64'd2, "R11", 1'b0, 64'h22);
   endtask

   task automatic t_overlap;
      inv_all = 1'b1;
      cmd_valid = 1'b1; cmd_op = 2'd0;
      cmd_index = idx256(36'h321, 2); cmd_data = 64'h2B;
      @(negedge clk);
      inv_all = 1'b0; cmd_valid = 1'b0;
      chk("R12", "flush", 64'(tlb_flush), 64'd1);
      chk("R12", "store err", 64'(cmd_err), 64'd0);
      do_lookup(a256(36'h321, 28'h5), "R12", 1'b1, 2, 64'h2B);
      do_lookup(a256(36'h123, 28'h0), "R12", 1'b0, 0, 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_seg256();
      t_seg1t();
      t_priority();
      t_store_rules();
      t_clear_all();
      t_clear_addr();
      t_read_rules();
      t_overlap();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule